// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a software-readable record of which reset sources were behind the most recent resets. It watches one request line for each cold-domain source and one for each warm-domain source. It also receives two single-cycle strobes from the reset sequencer: one when a cold reset finishes and one when a warm reset finishes. Software reads the record as a single vector and clears individual bits by writing ones.

A cold completion replaces the whole record. Only the cold source or sources whose requests were released last survive. To do this, the block keeps a shadow of the most recent release edges among the cold requests. A warm completion adds the bits of every warm source that requested since the previous completion, and leaves the bits already present untouched. Bits therefore accumulate across warm resets until the next cold reset or until software clears them.

Top module: `rstcause_status`

## Requirements
- R1: After the power-on reset input is released, `status` reads all zeros until the first completion strobe or write changes it.
- R2: Bit i of `status` (0 <= i < N_COLD) belongs to cold source i, and bit N_COLD+j belongs to warm source j. One cycle after `cold_done`, every warm bit is 0 and the cold bits hold the recorded cold source(s). If no cold request fell since the previous cold completion, the cold bits are 0 as well.
- R3: When cold requests overlap, only the source whose request falls last is recorded at cold completion. Earlier falls are overwritten.
- R4: When several cold requests fall in the same cycle, and that cycle is the last fall before `cold_done`, all of their bits are set.
- R5: One cycle after `warm_done`, the bit of every warm source whose request was high at any cycle since the previous completion strobe is 1. This includes a request that is high in the strobe cycle itself.
- R6: A warm completion never clears a bit of `status`.
- R7: When `wr_en` is 1, each bit of `wr_data` that is 1 clears the matching `status` bit on the next edge. Bits written as 0 keep their value.
- R8: If a completion sets a bit in the same cycle that software clears it, the bit ends up set.
- R9: If `cold_done` and `warm_done` arrive together, the cold completion takes effect and the warm one is discarded. The warm sources collected so far are dropped, so a later `warm_done` with no new warm request leaves `status` unchanged.
- R10: `status` changes only on the edge after a completion strobe or a write. In every other cycle it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| cold_req | input | N_COLD | Per-source cold reset requests, active high |
| warm_req | input | N_WARM | Per-source warm reset requests, active high |
| cold_done | input | 1 | Single-cycle strobe: cold reset sequence finished |
| warm_done | input | 1 | Single-cycle strobe: warm reset sequence finished |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | N_COLD+N_WARM | Write-one-to-clear mask |
| status | output | N_COLD+N_WARM | Recorded reset causes |

## Verification
The bench builds the block with N_COLD=3 and N_WARM=4. Three cold lines are enough to have two requests overlap with staggered releases while a third stays idle, and also to release two requests in the same cycle. Four warm lines allow bits to pile up over several warm completions, one of them with its request still high in the strobe cycle. With seven status bits, the cold/warm boundary and mixed set-and-clear patterns on the same edge can all be checked.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;

    // Which update the status register applies on the coming edge.
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_WARM = 2'd1,
        EV_COLD = 2'd2
    } rc_event_e;

    function automatic rc_event_e pick_event(input logic cold_done, input logic warm_done);
        if (cold_done)      return EV_COLD;
        else if (warm_done) return EV_WARM;
        else                return EV_NONE;
    endfunction

endpackage

// File: rtl/rc_cold_tracker.sv
// Remembers the most recent falling edge(s) among the cold request lines.
module rc_cold_tracker #(
    parameter int N_COLD = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_COLD-1:0] cold_req,
    input  logic              cold_done,
    output logic [N_COLD-1:0] cold_src
);
    typedef struct packed {
        logic [N_COLD-1:0] prev;
        logic [N_COLD-1:0] shadow;
    } trk_t;

    trk_t              st_d, st_q;
    logic [N_COLD-1:0] fall;

    always_comb begin
        st_d      = st_q;
        fall      = st_q.prev & ~cold_req;
        st_d.prev = cold_req;
        // A fresh release replaces the older record entirely.
        if (|fall) st_d.shadow = fall;
        // The record is consumed by a completion.
        if (cold_done) st_d.shadow = '0;
        cold_src = (|fall) ? fall : st_q.shadow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rc_warm_collector.sv
// Gathers warm requests seen since the previous completion.
module rc_warm_collector #(
    parameter int N_WARM = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_WARM-1:0] warm_req,
    input  logic              warm_done,
    input  logic              cold_done,
    output logic [N_WARM-1:0] warm_src
);
    typedef struct packed {
        logic [N_WARM-1:0] seen;
    } col_t;

    col_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        warm_src = st_q.seen | warm_req;
        if (warm_done || cold_done) st_d.seen = '0;
        else                        st_d.seen = warm_src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rc_status_reg.sv
// The software-visible record with write-one-to-clear access.
module rc_status_reg
    import rstcause_pkg::*;
#(
    parameter int N_COLD = 3,
    parameter int N_WARM = 4,
    localparam int W     = N_COLD + N_WARM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cold_done,
    input  logic              warm_done,
    input  logic [N_COLD-1:0] cold_src,
    input  logic [N_WARM-1:0] warm_src,
    input  logic              wr_en,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      status
);
    typedef struct packed {
        logic [W-1:0] bits;
    } sts_t;

    sts_t         st_d, st_q;
    rc_event_e    ev;
    logic [W-1:0] base;
    logic [W-1:0] set_vec;
    logic [W-1:0] clr_vec;

    always_comb begin
        ev      = pick_event(cold_done, warm_done);
        clr_vec = wr_en ? wr_data : '0;
        base    = st_q.bits;
        set_vec = '0;
        case (ev)
            EV_COLD: begin
                base    = '0;
                set_vec = {{N_WARM{1'b0}}, cold_src};
            end
            EV_WARM: set_vec = {warm_src, {N_COLD{1'b0}}};
            default: set_vec = '0;
        endcase
        // Hardware set wins over a software clear on the same edge.
        st_d.bits = (base & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.bits;
endmodule

// File: rtl/rstcause_status.sv
module rstcause_status #(
    parameter int N_COLD = 3,
    parameter int N_WARM = 4,
    localparam int W     = N_COLD + N_WARM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_COLD-1:0] cold_req,
    input  logic [N_WARM-1:0] warm_req,
    input  logic              cold_done,
    input  logic              warm_done,
    input  logic              wr_en,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      status
);
    logic [N_COLD-1:0] cold_src;
    logic [N_WARM-1:0] warm_src;

    rc_cold_tracker #(.N_COLD(N_COLD)) cold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cold_req  (cold_req),
        .cold_done (cold_done),
        .cold_src  (cold_src)
    );

    rc_warm_collector #(.N_WARM(N_WARM)) warm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .warm_req  (warm_req),
        .warm_done (warm_done),
        .cold_done (cold_done),
        .warm_src  (warm_src)
    );

    rc_status_reg #(.N_COLD(N_COLD), .N_WARM(N_WARM)) sts_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cold_done (cold_done),
        .warm_done (warm_done),
        .cold_src  (cold_src),
        .warm_src  (warm_src),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .status    (status)
    );
endmodule

// File: rtl/rstcause_status_chk.sv
module rstcause_status_chk #(
    parameter int N_COLD = 3,
    parameter int N_WARM = 4,
    localparam int W     = N_COLD + N_WARM
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_WARM-1:0] warm_req,
    input logic              cold_done,
    input logic              warm_done,
    input logic              wr_en,
    input logic [W-1:0]      wr_data,
    input logic [W-1:0]      status
);
    logic [W-1:0] warm_mask;
    assign warm_mask = {warm_req, {N_COLD{1'b0}}};

    // R2: a cold completion leaves no warm bit behind
    p_cold_wipe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cold_done |=> (status[W-1:N_COLD] == '0));

    // R6: a warm completion clears nothing
    p_warm_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_done && !cold_done && !wr_en) |=> ((status & $past(status)) == $past(status)));

    // R5: requesting warm sources are recorded
    p_warm_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_done && !cold_done) |=> ((status & $past(warm_mask)) == $past(warm_mask)));

    // R7: written ones clear bits outside completion cycles
    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cold_done && !warm_done) |=> (status == ($past(status) & ~$past(wr_data))));

    // R10: no strobe, no write, no change
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !cold_done && !warm_done) |=> $stable(status));
endmodule

bind rstcause_status rstcause_status_chk #(.N_COLD(N_COLD), .N_WARM(N_WARM)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .warm_req  (warm_req),
    .cold_done (cold_done),
    .warm_done (warm_done),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .status    (status)
);

// File: tb/rstcause_status_tb_top.sv
module rstcause_status_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 3;
    localparam int NWM = 4;
    localparam int W = NC + NWM;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] cold_req = '0;
    logic [NWM-1:0] warm_req = '0;
    logic          cold_done = 1'b0;
    logic          warm_done = 1'b0;
    logic          wr_en = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  status;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstcause_status #(.N_COLD(NC), .N_WARM(NWM)) dut_i (
        .clk(clk), .rst_n(rst_n), .cold_req(cold_req), .warm_req(warm_req),
        .cold_done(cold_done), .warm_done(warm_done), .wr_en(wr_en),
        .wr_data(wr_data), .status(status)
    );

    task automatic check(input string tag, input logic [W-1:0] exp);
        n_chk++;
        if (status !== exp) begin
            n_err++;
            $display("FAIL %s: status=%h expected=%h", tag, status, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One-cycle strobe helpers: drive at a negedge, release at the next.
    task automatic pulse_warm_done();
        warm_done = 1'b1; tick(1); warm_done = 1'b0;
    endtask
    task automatic pulse_cold_done();
        cold_done = 1'b1; tick(1); cold_done = 1'b0;
    endtask
    task automatic sw_write(input logic [W-1:0] m);
        wr_en = 1'b1; wr_data = m; tick(1); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic t_reset();
        tick(3);
        check("R1 after reset", 7'h00);
    endtask

    task automatic t_warm_basic();
        warm_req[1] = 1'b1; tick(2); warm_req[1] = 1'b0; tick(2);
        check("R10 no change before strobe", 7'h00);
        pulse_warm_done();
        check("R5 warm source 1 -> bit4", 7'h10);
    endtask

    task automatic t_warm_accum();
        warm_req[3] = 1'b1; tick(1); warm_req[3] = 1'b0; tick(1);
        pulse_warm_done();
        check("R6 accumulate bit6", 7'h50);
        warm_req[0] = 1'b1; warm_done = 1'b1; tick(1);
        warm_done = 1'b0; warm_req[0] = 1'b0;
        check("R5 request in strobe cycle -> bit3", 7'h58);
    endtask

    task automatic t_w1c();
        sw_write(7'h10);
        check("R7 clear bit4", 7'h48);
        sw_write(7'h00);
        check("R7 zero write keeps bits", 7'h48);
    endtask

    task automatic t_cold_overlap();
        cold_req = 3'b011; tick(2);
        cold_req = 3'b010; tick(2);
        cold_req = 3'b000; tick(2);
        check("R10 cold release alone no change", 7'h48);
        pulse_cold_done();
        check("R3 last released cold source 1", 7'h02);
    endtask

    task automatic t_cold_same_cycle();
        cold_req = 3'b101; tick(2);
        cold_req = 3'b000; tick(1);
        pulse_cold_done();
        check("R4 simultaneous release", 7'h05);
    endtask

    task automatic t_cold_none();
        pulse_cold_done();
        check("R2 cold completion without release wipes all", 7'h00);
        sw_write(7'h00);
    endtask

    task automatic t_set_wins();
        cold_req = 3'b001; tick(1); cold_req = 3'b000; tick(1);
        pulse_cold_done();
        check("R2 cold source 0", 7'h01);
        warm_req[2] = 1'b1; tick(1); warm_req[2] = 1'b0;
        // Clear bit5 (being set) and bit0 (not being set) on the strobe edge.
        warm_done = 1'b1; wr_en = 1'b1; wr_data = 7'h21; tick(1);
        warm_done = 1'b0; wr_en = 1'b0; wr_data = '0;
        check("R8 set beats clear", 7'h20);
    endtask

    task automatic t_cold_priority();
        warm_req[0] = 1'b1; tick(1); warm_req[0] = 1'b0;
        cold_req[2] = 1'b1; tick(1); cold_req[2] = 1'b0; tick(1);
        cold_done = 1'b1; warm_done = 1'b1; tick(1);
        cold_done = 1'b0; warm_done = 1'b0;
        check("R9 cold wins over warm", 7'h04);
        tick(1);
        pulse_warm_done();
        check("R9 collected warm sources dropped", 7'h04);
        sw_write(7'h7F);
        check("R7 clear all", 7'h00);
    endtask

    initial begin
        tick(2);
        check("R1 during reset", 7'h00);
        rst_n = 1'b1;
        t_reset();
        t_warm_basic();
        t_warm_accum();
        t_w1c();
        t_cold_overlap();
        t_cold_same_cycle();
        t_cold_none();
        t_set_wins();
        t_cold_priority();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end
endmodule